// File: doc/BRIEF.md
# Prescaled PWM Generator With Heartbeat

This block produces one pulse-width modulated signal from a small register file. A prescaler divides one of two tick sources, chosen by a control bit: a fast tick that follows the main clock and a slow tick at a low rate, for example 32 kHz, that keeps running while the rest of the chip sleeps. A period counter runs over a programmed number of prescaled ticks. The output is active for the first `duty` ticks of each period. The output can be inverted. It can also be turned into an emulated open-drain drive: the data pin is then held low and a separate output-enable pin does the switching.

Two tick sources are passed in as single-cycle enables in the `clk` domain, so the block uses only one clock. Writes to the prescaler, cycle and duty registers are staged. While the block runs, they reach the counters only at a period boundary, and no period is ever cut short or stretched. A heartbeat mode lowers the duty in a triangle pattern over 256 periods to give a slow breathing effect. The register port is a plain write strobe with a combinational read. It carries configuration only, so it has no valid/ready handshake and no back-pressure.

Top module: `pwm_hb_top`

## Requirements
- R1: After reset every register reads 0, `pwm_o` is 0 and `pwm_oe_o` is 1.
- R2: Register map (2-bit address): 0 = control, with bit0 enable, bit1 invert, bit2 slow-clock select, bit3 open-drain and bits[5:4] heartbeat mode. 1 = prescaler (8 bits). 2 = cycle (16 bits). 3 = duty (16 bits). A read returns the last value written, and the unused bits of the control register read as 0.
- R3: A period lasts `cycle` prescaled ticks. The output is active for the first min(duty, cycle) ticks of the period. A duty of 0 or a cycle of 0 keeps the output inactive, and a duty of `cycle` or more keeps it active.
- R4: A prescaler value p produces one prescaled tick for every p+1 pulses of the selected tick source. A value of 0 passes the source through unchanged.
- R5: While enable is 0 the prescaler and period counters are held at zero and the output stays at its inactive level.
- R6: With invert set, the level driven is the complement of the active state. Inactive then means high.
- R7: With open-drain set, `pwm_o` is always 0 and `pwm_oe_o` is 1 exactly when the level would be low. With open-drain clear, `pwm_oe_o` is 1 and `pwm_o` carries the level.
- R8: Slow-clock select 0 counts `fast_tick_i` pulses and 1 counts `slow_tick_i` pulses.
- R9: While enabled, new prescaler, cycle and duty values take effect only at the next period boundary. While disabled they take effect at once.
- R10: Heartbeat modes 1, 2 and 3 use a phase counter that starts at 0 on enable and advances at every period end. The terms are d = min(duty, cycle), ph = the phase, down = ph when ph < 128 and 255-ph otherwise, and s = 9, 8 or 7 for modes 1, 2 and 3. The effective duty is d - ((d*down) >> s). Mode 0 applies no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_tick_i | input | 1 | Fast tick source enable |
| slow_tick_i | input | 1 | Slow tick source enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| pwm_o | output | 1 | PWM data output |
| pwm_oe_o | output | 1 | Output enable for the pad |

## Verification
A register write lands on the clock edge that samples the strobe, and readback and the control bits take effect in the cycle right after it. The output follows the period counter with no output register, so a change of counter state is visible in the same cycle. Duty, prescaler, clock-select, polarity, open-drain and heartbeat results are counted over a window of whole output periods, measured in clock cycles, so the sum does not depend on the phase the window starts at. The staged-update check follows the counter cycle by cycle after enable: the output is 0 in every cycle up to the last tick of the running period and is 1 from the first cycle of the next period.

// File: rtl/pwm_hb_pkg.sv
package pwm_hb_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_PRESC = 2'd1;
  localparam logic [ADDR_W-1:0] A_CYCLE = 2'd2;
  localparam logic [ADDR_W-1:0] A_DUTY  = 2'd3;
  localparam int CTRL_W = 6;

  typedef enum logic [1:0] {
    HB_OFF = 2'd0,
    HB_Q   = 2'd1,
    HB_H   = 2'd2,
    HB_F   = 2'd3
  } hb_mode_e;

  typedef struct packed {
    hb_mode_e hb;
    logic     open_drain;
    logic     clk_slow;
    logic     invert;
    logic     enable;
  } ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_hb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output ctrl_t             ctrl,
  output logic [PRE_W-1:0]  presc,
  output logic [CNT_W-1:0]  cycle,
  output logic [CNT_W-1:0]  duty,
  output logic [CNT_W-1:0]  rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      presc <= '0;
      cycle <= '0;
      duty  <= '0;
    end else if (wr_en) begin
      unique case (addr)
        A_CTRL:  ctrl  <= ctrl_t'(wdata[CTRL_W-1:0]);
        A_PRESC: presc <= wdata[PRE_W-1:0];
        A_CYCLE: cycle <= wdata;
        default: duty  <= wdata;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL:  rdata[CTRL_W-1:0] = ctrl;
      A_PRESC: rdata[PRE_W-1:0]  = presc;
      A_CYCLE: rdata = cycle;
      default: rdata = duty;
    endcase
  end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sel_slow,
  input  logic             fast_tick,
  input  logic             slow_tick,
  input  logic [PRE_W-1:0] presc_next,
  input  logic             load,
  output logic             tick
);
  logic [PRE_W-1:0] pre_cnt, act_presc;
  logic src;

  assign src  = sel_slow ? slow_tick : fast_tick;
  assign tick = en && src && (pre_cnt == act_presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      act_presc <= '0;
    end else if (!en) begin
      pre_cnt   <= '0;
      act_presc <= presc_next;
    end else if (src) begin
      pre_cnt <= (pre_cnt == act_presc) ? '0 : pre_cnt + 1'b1;
      if (load) act_presc <= presc_next;
    end
  end

  a_r4_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> pre_cnt <= act_presc);
  a_r5_pre_held: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pre_cnt == '0);
endmodule

// File: rtl/pwm_period.sv
module pwm_period #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] cycle_next,
  input  logic [CNT_W-1:0] duty_next,
  output logic             period_end,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] base_duty
);
  logic [CNT_W-1:0] act_cycle, act_duty;
  logic [CNT_W:0]   cnt_inc;
  logic             last;

  assign cnt_inc    = {1'b0, cnt} + 1'b1;
  assign last       = cnt_inc >= {1'b0, act_cycle};
  assign period_end = tick && last;
  assign base_duty  = (act_duty > act_cycle) ? act_cycle : act_duty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      act_cycle <= '0;
      act_duty  <= '0;
    end else if (!en) begin
      cnt       <= '0;
      act_cycle <= cycle_next;
      act_duty  <= duty_next;
    end else if (tick) begin
      if (last) begin
        cnt       <= '0;
        act_cycle <= cycle_next;
        act_duty  <= duty_next;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cycle != '0) |-> cnt < act_cycle);
  a_r5_cnt_held: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0);
  a_r9_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !period_end) |=> ($stable(act_duty) && $stable(act_cycle)));
endmodule

// File: rtl/pwm_heartbeat.sv
module pwm_heartbeat
  import pwm_hb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int HB_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             period_end,
  input  hb_mode_e         mode,
  input  logic [CNT_W-1:0] base_duty,
  output logic [CNT_W-1:0] eff_duty
);
  localparam int TRI_W  = HB_W - 1;
  localparam int PROD_W = CNT_W + TRI_W;

  logic [HB_W-1:0]   phase;
  logic [TRI_W-1:0]  down;
  logic [PROD_W-1:0] prod, red;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase <= '0;
    else if (!en)        phase <= '0;
    else if (period_end) phase <= phase + 1'b1;
  end

  assign down = phase[HB_W-1] ? ~phase[TRI_W-1:0] : phase[TRI_W-1:0];
  assign prod = PROD_W'(base_duty) * PROD_W'(down);

  always_comb begin
    unique case (mode)
      HB_Q:    red = prod >> (TRI_W + 2);
      HB_H:    red = prod >> (TRI_W + 1);
      HB_F:    red = prod >> TRI_W;
      default: red = '0;
    endcase
  end

  assign eff_duty = base_duty - red[CNT_W-1:0];

  a_r10_hb_not_above: assert property (@(posedge clk) disable iff (!rst_n)
    eff_duty <= base_duty);
  a_r10_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> phase == '0);
endmodule

// File: rtl/pwm_hb_top.sv
module pwm_hb_top
  import pwm_hb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  parameter int HB_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_tick_i,
  input  logic              slow_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              pwm_o,
  output logic              pwm_oe_o
);
  ctrl_t            ctrl;
  logic [PRE_W-1:0] presc;
  logic [CNT_W-1:0] cycle, duty, cnt, base_duty, eff_duty;
  logic             tick, period_end, active, level;

  pwm_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i), .wdata(wdata_i),
    .ctrl(ctrl), .presc(presc), .cycle(cycle), .duty(duty), .rdata(rdata_o)
  );

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(ctrl.enable), .sel_slow(ctrl.clk_slow),
    .fast_tick(fast_tick_i), .slow_tick(slow_tick_i), .presc_next(presc),
    .load(period_end), .tick(tick)
  );

  pwm_period #(.CNT_W(CNT_W)) u_per (
    .clk(clk), .rst_n(rst_n), .en(ctrl.enable), .tick(tick),
    .cycle_next(cycle), .duty_next(duty), .period_end(period_end),
    .cnt(cnt), .base_duty(base_duty)
  );

  pwm_heartbeat #(.CNT_W(CNT_W), .HB_W(HB_W)) u_hb (
    .clk(clk), .rst_n(rst_n), .en(ctrl.enable), .period_end(period_end),
    .mode(ctrl.hb), .base_duty(base_duty), .eff_duty(eff_duty)
  );

  assign active   = ctrl.enable && (cnt < eff_duty);
  assign level    = active ^ ctrl.invert;
  assign pwm_o    = ctrl.open_drain ? 1'b0 : level;
  assign pwm_oe_o = ctrl.open_drain ? ~level : 1'b1;

  a_r7_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.open_drain |-> !pwm_o);
  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.enable && !ctrl.open_drain) |-> pwm_o == ctrl.invert);
endmodule

// File: tb/test_pwm_hb_top.sv
module test_pwm_hb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_tick = 1'b1;
  logic slow_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic pwm, oe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_hb_top i_pwm_hb_top (
    .clk(clk), .rst_n(rst_n), .fast_tick_i(fast_tick), .slow_tick_i(slow_tick),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pwm_o(pwm), .pwm_oe_o(oe)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic count(input int n, output int hi, output int oen);
    hi = 0; oen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi += int'(pwm);
      oen += int'(oe);
    end
  endtask

  task automatic setup(input logic [15:0] ctl, input int p, input int c, input int d);
    wr(2'd0, 16'd0);
    wr(2'd1, 16'(p));
    wr(2'd2, 16'(c));
    wr(2'd3, 16'(d));
    wr(2'd0, ctl);
  endtask

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    int hi, oen, win, exp_hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(pwm == 1'b0, "R1 pwm", int'(pwm), 0);
    chk(oe == 1'b1, "R1 oe", int'(oe), 1);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk(r == 16'd0, "R1 reg", int'(r), 0);
    end

    // R2 readback, unused control bits read 0
    wr(2'd0, 16'hFFF6); rd(2'd0, r); chk(r == 16'h0036, "R2 ctrl", int'(r), 'h36);
    wr(2'd1, 16'h12A5); rd(2'd1, r); chk(r == 16'h00A5, "R2 presc", int'(r), 'hA5);
    wr(2'd2, 16'hBEEF); rd(2'd2, r); chk(r == 16'hBEEF, "R2 cycle", int'(r), 'hBEEF);
    wr(2'd3, 16'h1234); rd(2'd3, r); chk(r == 16'h1234, "R2 duty", int'(r), 'h1234);
    wr(2'd0, 16'h0000);

    // R3 R4 sweep on the fast source
    for (int p = 0; p < 3; p++)
      for (int c = 0; c < 6; c++)
        for (int d = 0; d < 7; d++) begin
          setup(16'h0001, p, c, d);
          win = (c == 0) ? 20 : 2 * c * (p + 1);
          exp_hi = (c == 0) ? 0 : 2 * mn(d, c) * (p + 1);
          count(win, hi, oen);
          chk(hi == exp_hi, "R3 R4 duty sweep", hi, exp_hi);
        end

    // R6 invert
    setup(16'h0003, 1, 5, 2);
    count(20, hi, oen);
    chk(hi == 12, "R6 inverted high count", hi, 12);

    // R7 open-drain
    setup(16'h0009, 0, 8, 3);
    count(16, hi, oen);
    chk(hi == 0, "R7 pwm held low", hi, 0);
    chk(oen == 10, "R7 oe when low", oen, 10);
    setup(16'h0001, 0, 8, 3);
    count(16, hi, oen);
    chk(oen == 16, "R7 push-pull oe", oen, 16);

    // R8 slow source, one pulse every 4 clocks
    setup(16'h0005, 1, 3, 2);
    count(48, hi, oen);
    chk(hi == 32, "R8 slow source", hi, 32);
    setup(16'h0005, 0, 4, 1);
    count(32, hi, oen);
    chk(hi == 8, "R8 slow source p0", hi, 8);

    // R5 disabled output level
    setup(16'h0001, 0, 4, 4);
    wr(2'd0, 16'h0000);
    count(10, hi, oen);
    chk(hi == 0, "R5 idle low", hi, 0);
    wr(2'd0, 16'h0002);
    count(10, hi, oen);
    chk(hi == 10, "R5 idle inverted high", hi, 10);
    wr(2'd0, 16'h000A);
    count(10, hi, oen);
    chk(oen == 0, "R5 R7 idle inverted released", oen, 0);

    // R9 staged duty update at the period boundary
    setup(16'h0001, 0, 10, 0);
    wr(2'd3, 16'd10);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      chk(pwm == 1'b0, "R9 old duty kept", int'(pwm), 0);
    end
    count(10, hi, oen);
    chk(hi == 10, "R9 new duty after boundary", hi, 10);

    // R10 heartbeat modes over 256 periods of 64 cycles
    for (int m = 0; m < 4; m++) begin
      exp_hi = 0;
      for (int ph = 0; ph < 256; ph++) begin
        int dn;
        dn = (ph < 128) ? ph : 255 - ph;
        exp_hi += (m == 0) ? 64 : 64 - ((64 * dn) >> (7 + 3 - m));
      end
      setup(16'(1 | (m << 4)), 0, 64, 64);
      count(256 * 64, hi, oen);
      chk(hi == exp_hi, "R10 heartbeat total", hi, exp_hi);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule